// File: doc/BRIEF.md
# Host-to-User Streaming Receive Endpoint

This endpoint takes a burst of 64-bit words from a host-side master and holds them in a dual-clock FIFO. User logic runs on its own clock and drains the FIFO. The host side is a plain valid/data port with a start marker and an end marker. The host writes whenever it has a word. A full flag tells it when a word would be dropped.

On the user side the block gives one-cycle start and done pulses that have been moved into the user clock domain. It also gives a read strobe, a registered data output whose valid flag follows the read by one cycle, an empty flag and a word count. The word count is deliberately cautious. It is built from a write pointer that is synchronized into the user domain, so it can trail the true fill level but never run ahead of it. A user flush discards everything stored and holds the FIFO empty for three user cycles. The flush input can be tied directly to the start pulse.

Top module: `stream_rx_endpoint`

## Requirements
- R1: The FIFO stores up to 511 words. `h_full` is high once 511 words are held. A host word offered while `h_full` is high is dropped and never reaches the user side.
- R2: Each host `h_start` pulse produces `u_start` high for exactly one user-clock cycle.
- R3: Each host `h_end` pulse produces `u_done` high for exactly one user-clock cycle.
- R4: A read accepted at a user clock edge (`u_read` high while `u_empty` is low) drives `u_valid` high for one cycle after that edge. `u_data` then carries the next stored word, and words come out in the order the host wrote them.
- R5: `u_empty` is low while stored words are visible to the user side. It goes high in the same cycle that the last word appears with `u_valid`, and it stays high while nothing is stored.
- R6: A read issued while `u_empty` is high is an underflow. It gives no `u_valid`, and it does not move the read position: the next word written is the next word read.
- R7: `u_count` never exceeds the number of words actually stored. Once the host has been idle for a few user cycles, it equals that number.
- R8: When `u_fifo_rst` is sampled high, all stored words are discarded. `u_empty` is then high and `u_count` is zero for at least the next three user cycles, and reads during that time are ignored. Words written afterwards are read back normally.
- R9: `u_empty` is high exactly when `u_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host-side clock |
| hrst_n | input | 1 | Host-side active-low reset |
| h_start | input | 1 | One-cycle marker for the start of a host transfer |
| h_valid | input | 1 | Host offers a word on `h_data` |
| h_data | input | 64 | Host data word |
| h_end | input | 1 | One-cycle marker for the end of a host transfer |
| h_full | output | 1 | FIFO holds 511 words, so an offered word is dropped |
| uclk | input | 1 | User-side clock |
| urst_n | input | 1 | User-side active-low reset |
| u_fifo_rst | input | 1 | User flush request |
| u_read | input | 1 | User read strobe |
| u_start | output | 1 | One-cycle pulse: a transfer has started |
| u_done | output | 1 | One-cycle pulse: a transfer has finished |
| u_data | output | 64 | Word read out, registered |
| u_valid | output | 1 | `u_data` carries a word read on the previous edge |
| u_count | output | 9 | Conservative count of stored words |
| u_empty | output | 1 | No word is available for reading |

## Verification
The hardest state to reach is a full FIFO, because any reading while the host writes keeps it below the threshold. The stimulus therefore writes 511 words with the reader idle, tries extra writes against `h_full`, and checks that none of them appear in the drain. It also checks that `u_empty` rises with the last word. The over-report property is watched on every user cycle while random bursts and random read strobes run at the same time on unrelated clocks. Separate directed steps cover an underflow read and a flush issued with a read strobe held high.

// File: rtl/srx_pkg.sv
package srx_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer for a vector that changes at most one bit at a time.
module rx_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[LAST];
endmodule

// File: rtl/rx_pulse_xing.sv
// Turns a toggle from another clock domain into a one-cycle pulse.
module rx_pulse_xing #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    typedef struct packed {
        logic last;
        logic pulse;
    } xing_t;

    logic  tog_s;
    xing_t x_d, x_q;

    rx_sync #(.WIDTH(1), .STAGES(STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tog_in),
        .dout  (tog_s)
    );

    always_comb begin
        x_d       = x_q;
        x_d.last  = tog_s;
        x_d.pulse = tog_s ^ x_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign pulse = x_q.pulse;
endmodule

// File: rtl/rx_dpram.sv
// Simple dual-port storage: write on one clock, registered read on the other.
module rx_dpram #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/stream_rx_endpoint.sv
module stream_rx_endpoint
    import srx_pkg::*;
#(
    parameter int DATA_W       = 64,
    parameter int ADDR_W       = 9,
    parameter int SYNC_STAGES  = 2,
    parameter int FLUSH_CYCLES = 3
) (
    input  logic              hclk,
    input  logic              hrst_n,
    input  logic              h_start,
    input  logic              h_valid,
    input  logic [DATA_W-1:0] h_data,
    input  logic              h_end,
    output logic              h_full,
    input  logic              uclk,
    input  logic              urst_n,
    input  logic              u_fifo_rst,
    input  logic              u_read,
    output logic              u_start,
    output logic              u_done,
    output logic [DATA_W-1:0] u_data,
    output logic              u_valid,
    output logic [ADDR_W-1:0] u_count,
    output logic              u_empty
);
    localparam int              PTR_W    = ADDR_W + 1;
    localparam int              DEPTH    = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] CAPACITY = PTR_W'(DEPTH - 1);
    localparam int              FC_W     = $clog2(FLUSH_CYCLES + 1);

    // ---------------- host domain ----------------
    typedef struct packed {
        logic [PTR_W-1:0] wbin;
        logic [PTR_W-1:0] wgray;
        logic             start_tog;
        logic             end_tog;
    } hside_t;

    hside_t           h_d, h_q;
    logic [PTR_W-1:0] rgray_hs, rbin_hs, h_fill;
    logic             wr_en;

    // ---------------- user domain ----------------
    typedef struct packed {
        logic [PTR_W-1:0] rbin;
        logic [PTR_W-1:0] rgray;
        logic             valid;
        logic [FC_W-1:0]  flush_cnt;
    } uside_t;

    uside_t           u_d, u_q;
    logic [PTR_W-1:0] wgray_us, wbin_us, u_fill;
    logic             flushing, rd_en, empty_c;

    // Read pointer into the host domain; free space is judged against it.
    rx_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) rptr_sync_i (
        .clk   (hclk),
        .rst_n (hrst_n),
        .din   (u_q.rgray),
        .dout  (rgray_hs)
    );

    assign rbin_hs = PTR_W'(gray_to_bin(32'(rgray_hs)));
    assign h_fill  = h_q.wbin - rbin_hs;
    assign h_full  = (h_fill >= CAPACITY);
    assign wr_en   = h_valid && !h_full;

    always_comb begin
        h_d = h_q;
        if (wr_en) begin
            h_d.wbin  = h_q.wbin + 1'b1;
            h_d.wgray = PTR_W'(bin_to_gray(32'(h_d.wbin)));
        end
        if (h_start) h_d.start_tog = !h_q.start_tog;
        if (h_end)   h_d.end_tog   = !h_q.end_tog;
    end

    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) h_q <= '0;
        else         h_q <= h_d;
    end

    // Write pointer into the user domain; the count lags behind it.
    rx_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) wptr_sync_i (
        .clk   (uclk),
        .rst_n (urst_n),
        .din   (h_q.wgray),
        .dout  (wgray_us)
    );

    rx_pulse_xing #(.STAGES(SYNC_STAGES)) start_xing_i (
        .clk    (uclk),
        .rst_n  (urst_n),
        .tog_in (h_q.start_tog),
        .pulse  (u_start)
    );

    rx_pulse_xing #(.STAGES(SYNC_STAGES)) done_xing_i (
        .clk    (uclk),
        .rst_n  (urst_n),
        .tog_in (h_q.end_tog),
        .pulse  (u_done)
    );

    assign wbin_us  = PTR_W'(gray_to_bin(32'(wgray_us)));
    assign u_fill   = wbin_us - u_q.rbin;
    assign flushing = u_fifo_rst || (u_q.flush_cnt != '0);
    assign empty_c  = flushing || (u_fill == '0);
    assign rd_en    = u_read && !empty_c;

    always_comb begin
        u_d       = u_q;
        u_d.valid = rd_en;
        if (rd_en) u_d.rbin = u_q.rbin + 1'b1;
        if (u_fifo_rst)                u_d.flush_cnt = FC_W'(FLUSH_CYCLES);
        else if (u_q.flush_cnt != '0)  u_d.flush_cnt = u_q.flush_cnt - 1'b1;
        // Flush: skip the read side up to everything written so far.
        if (flushing) u_d.rbin = wbin_us;
        u_d.rgray = PTR_W'(bin_to_gray(32'(u_d.rbin)));
    end

    always_ff @(posedge uclk or negedge urst_n) begin
        if (!urst_n) u_q <= '0;
        else         u_q <= u_d;
    end

    rx_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
        .wclk  (hclk),
        .we    (wr_en),
        .waddr (h_q.wbin[ADDR_W-1:0]),
        .wdata (h_data),
        .rclk  (uclk),
        .re    (rd_en),
        .raddr (u_q.rbin[ADDR_W-1:0]),
        .rdata (u_data)
    );

    assign u_valid = u_q.valid;
    assign u_empty = empty_c;
    assign u_count = flushing ? '0 : u_fill[ADDR_W-1:0];

endmodule

// File: rtl/stream_rx_endpoint_chk.sv
module stream_rx_endpoint_chk #(
    parameter int ADDR_W = 9
) (
    input logic              uclk,
    input logic              urst_n,
    input logic              u_fifo_rst,
    input logic              u_read,
    input logic              u_start,
    input logic              u_done,
    input logic              u_valid,
    input logic              u_empty,
    input logic [ADDR_W-1:0] u_count
);
    assert_start_single_R2: assert property (@(posedge uclk) disable iff (!urst_n)
        u_start |=> !u_start);

    assert_done_single_R3: assert property (@(posedge uclk) disable iff (!urst_n)
        u_done |=> !u_done);

    assert_valid_follows_read_R4: assert property (@(posedge uclk) disable iff (!urst_n)
        u_valid |-> $past(u_read && !u_empty));

    assert_no_underflow_valid_R6: assert property (@(posedge uclk) disable iff (!urst_n)
        (u_read && u_empty) |=> !u_valid);

    assert_flush_holds_empty_R8: assert property (@(posedge uclk) disable iff (!urst_n)
        u_fifo_rst |=> (u_empty && u_count == '0) ##1 u_empty ##1 u_empty);

    assert_empty_matches_count_R9: assert property (@(posedge uclk) disable iff (!urst_n)
        u_empty == (u_count == '0));
endmodule

bind stream_rx_endpoint stream_rx_endpoint_chk #(.ADDR_W(ADDR_W)) chk_i (
    .uclk       (uclk),
    .urst_n     (urst_n),
    .u_fifo_rst (u_fifo_rst),
    .u_read     (u_read),
    .u_start    (u_start),
    .u_done     (u_done),
    .u_valid    (u_valid),
    .u_empty    (u_empty),
    .u_count    (u_count)
);

// File: tb/stream_rx_endpoint_tb_top.sv
module stream_rx_endpoint_tb_top;
    localparam int CLK_PERIOD_NS  = 14;
    localparam int HCLK_PERIOD_NS = 20;
    localparam int CAP            = 511;

    logic        hclk = 0, uclk = 0;
    logic        hrst_n = 0, urst_n = 0;
    logic        h_start = 0, h_valid = 0, h_end = 0;
    logic [63:0] h_data = '0;
    logic        h_full;
    logic        u_fifo_rst = 0, u_read = 0;
    logic        u_start, u_done, u_valid, u_empty;
    logic [63:0] u_data;
    logic [8:0]  u_count;

    always #(CLK_PERIOD_NS/2)  uclk = ~uclk;
    always #(HCLK_PERIOD_NS/2) hclk = ~hclk;

    stream_rx_endpoint dut_i (
        .hclk(hclk), .hrst_n(hrst_n), .h_start(h_start), .h_valid(h_valid),
        .h_data(h_data), .h_end(h_end), .h_full(h_full),
        .uclk(uclk), .urst_n(urst_n), .u_fifo_rst(u_fifo_rst), .u_read(u_read),
        .u_start(u_start), .u_done(u_done), .u_data(u_data), .u_valid(u_valid),
        .u_count(u_count), .u_empty(u_empty)
    );

    int          n_checks = 0, n_fail = 0;
    logic [63:0] exp_q[$];
    int          occ = 0;
    int          starts = 0, dones = 0, wide_start = 0, wide_done = 0, over_rep = 0;
    logic        prev_start = 0, prev_done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Pulse and count monitors (R2, R3, R7).
    always @(negedge uclk) begin
        if (urst_n) begin
            if (u_start) starts++;
            if (u_done)  dones++;
            if (u_start && prev_start) wide_start++;
            if (u_done && prev_done)   wide_done++;
            if (int'(u_count) > occ)   over_rep++;
            prev_start <= u_start;
            prev_done  <= u_done;
        end
    end

    task automatic send_burst(input int n, input bit gaps);
        int sent = 0;
        @(negedge hclk) h_start = 1;
        @(negedge hclk) h_start = 0;
        while (sent < n) begin
            if (gaps && ($urandom % 4 == 0)) begin
                h_valid = 0;
                @(negedge hclk);
            end else begin
                bit acc;
                h_valid = 1;
                h_data  = {$urandom, $urandom};
                acc     = !h_full;
                @(posedge hclk);
                if (acc) begin
                    exp_q.push_back(h_data);
                    occ++;
                    sent++;
                end
                @(negedge hclk);
            end
        end
        h_valid = 0;
        h_end   = 1;
        @(negedge hclk) h_end = 0;
    endtask

    task automatic drain(input int n, input int rd_pct, input bit last_check);
        int  got = 0;
        bit  acc = 0;
        while (got < n) begin
            @(negedge uclk);
            if (acc) begin
                logic [63:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hdead;
                check(u_valid == 1'b1, "R4", "valid after read", longint'(u_valid), 1);
                check(u_data == e, "R4", "data order", longint'(u_data), longint'(e));
                got++;
                if (last_check && got == n)
                    check(u_empty == 1'b1, "R5", "empty with last word", longint'(u_empty), 1);
            end else begin
                check(u_valid == 1'b0, "R6", "no valid without read", longint'(u_valid), 0);
            end
            if (got < n) begin
                u_read = (($urandom % 100) < rd_pct);
                acc    = u_read && !u_empty;
                @(posedge uclk);
                if (acc) occ--;
            end
        end
        u_read = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge uclk);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge uclk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int s0, d0;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge uclk);
        hrst_n = 1;
        urst_n = 1;
        repeat (2) @(negedge uclk);

        // Reset state.
        check(u_empty == 1, "R5", "reset empty", longint'(u_empty), 1);
        check(u_count == 0, "R9", "reset count", longint'(u_count), 0);
        check(u_valid == 0, "R4", "reset valid", longint'(u_valid), 0);
        check(h_full == 0, "R1", "reset full", longint'(h_full), 0);

        // Directed: short burst, then read back, last-word empty.
        s0 = starts; d0 = dones;
        send_burst(5, 0);
        settle();
        check(u_count == 5, "R7", "settled count", longint'(u_count), 5);
        check(u_empty == 0, "R5", "not empty with data", longint'(u_empty), 0);
        check(starts == s0 + 1, "R2", "start pulses", starts, s0 + 1);
        check(dones == d0 + 1, "R3", "done pulses", dones, d0 + 1);
        drain(5, 100, 1);
        settle();
        check(u_empty == 1 && u_count == 0, "R5", "empty stays", longint'(u_count), 0);

        // Underflow read, then pointer must not have moved.
        @(negedge uclk) u_read = 1;
        @(negedge uclk);
        check(u_valid == 0, "R6", "underflow no valid", longint'(u_valid), 0);
        u_read = 0;
        send_burst(3, 0);
        settle();
        drain(3, 100, 1);

        // Fill to capacity with reader idle; extra writes are dropped.
        send_burst(CAP, 0);
        @(negedge hclk);
        check(h_full == 1, "R1", "full at 511", longint'(h_full), 1);
        for (int k = 0; k < 4; k++) begin
            h_valid = 1;
            h_data  = 64'hbad0_0000_0000_0000 | 64'(k);
            @(negedge hclk);
        end
        h_valid = 0;
        settle();
        check(u_count == 9'(CAP), "R1", "count at capacity", longint'(u_count), CAP);
        drain(CAP, 100, 1);
        settle();
        check(u_empty == 1 && u_count == 0, "R1", "dropped words absent", longint'(u_count), 0);

        // Flush with reads held high.
        send_burst(10, 0);
        settle();
        check(u_count == 10, "R7", "count before flush", longint'(u_count), 10);
        @(negedge uclk) begin u_fifo_rst = 1; u_read = 1; end
        @(negedge uclk) u_fifo_rst = 0;
        for (int k = 0; k < 3; k++) begin
            check(u_empty == 1 && u_count == 0, "R8", "flush hold", longint'(u_count), 0);
            check(u_valid == 0, "R8", "read ignored in flush", longint'(u_valid), 0);
            if (k < 2) @(negedge uclk);
        end
        u_read = 0;
        exp_q.delete();
        occ = 0;
        settle();
        check(u_empty == 1 && u_count == 0, "R8", "flushed stays empty", longint'(u_count), 0);
        send_burst(4, 0);
        settle();
        drain(4, 100, 1);

        // Random bursts with a concurrent random reader.
        for (int b = 0; b < 8; b++) begin
            int n;
            n = 1 + int'($urandom % 60);
            s0 = starts; d0 = dones;
            fork
                send_burst(n, 1);
                drain(n, 30 + int'($urandom % 70), 0);
            join
            settle();
            check(starts == s0 + 1, "R2", "random start pulse", starts, s0 + 1);
            check(dones == d0 + 1, "R3", "random done pulse", dones, d0 + 1);
            check(u_empty == 1, "R5", "empty after burst", longint'(u_empty), 1);
        end

        check(wide_start == 0, "R2", "start width", wide_start, 0);
        check(wide_done == 0, "R3", "done width", wide_done, 0);
        check(over_rep == 0, "R7", "count over-report cycles", over_rep, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule